// File: doc/BRIEF.md
# Shared Buffer Bus Arbiter

This block decides which of three masters may drive a shared buffer bus. The masters are a burst DMA channel from the disc data controller (the "local" channel), the CPU, and a single-byte DMA channel towards a slow instrument-bus interface (the "remote" channel). Each master raises a request and receives its own grant. When no grant is active, the arbiter is idle and samples all requests on every clock. From idle it grants exactly one master, using a fixed order: local first, CPU second, remote last.

A local or CPU grant lasts for as long as its owner keeps requesting. A remote grant always covers one byte and has a fixed length: `RWAIT` wait cycles followed by one data cycle. During the wait cycles a wait output tells the data controller to stretch its cycle. No grant is ever taken away early. When a grant ends, the bus is idle for at least one cycle before the next grant is given.

Top module: `dmabus_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `loc_ack`, `cpu_en`, `rem_ack` and `rem_wait` are all 0.
- R2: At most one of `loc_ack`, `cpu_en` and `rem_ack` is 1 in any cycle.
- R3: If no grant is active and `loc_req` is 1 at a clock edge, `loc_ack` is 1 after that edge, whatever the other requests are.
- R4: `loc_ack` stays 1 as long as `loc_req` is still 1 at each edge. It drops after the first edge at which `loc_req` is 0.
- R5: The CPU request `cpu_req_n` is active low. From idle, the CPU is granted (`cpu_en` = 1 after the edge) only when `cpu_req_n` is 0 and `loc_req` is 0. `cpu_en` then stays 1 while `cpu_req_n` remains 0.
- R6: From idle, `rem_ack` is raised only when `rem_req` is 1, `loc_req` is 0 and `cpu_req_n` is 1.
- R7: Every remote grant lasts exactly `RWAIT`+1 cycles (4 with the default `RWAIT` = 3). The length does not depend on `rem_req` during the grant.
- R8: `rem_wait` is 1 during the first `RWAIT` cycles of each remote grant and 0 in its final cycle. It is 0 whenever `rem_ack` is 0.
- R9: A grant is never pre-empted by a request of higher priority. After any grant ends, at least one cycle follows with no grant active.
- R10: If `rem_req` is held at 1, the remote byte grants repeat with exactly one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| loc_req | input | 1 | Local burst channel request, active high |
| loc_ack | output | 1 | Local channel grant |
| cpu_req_n | input | 1 | CPU bus request, active low |
| cpu_en | output | 1 | CPU grant |
| rem_req | input | 1 | Remote byte channel request, active high |
| rem_ack | output | 1 | Remote channel grant, one byte per grant |
| rem_wait | output | 1 | Wait-state indication to the data controller during a remote grant |

## Verification
The bound checker watches several rules on every cycle:
- grants are mutually exclusive;
- no grant passes directly to a different master;
- each new CPU or remote grant follows the required request levels;
- local and CPU grants are held while their owners keep requesting;
- a counter confirms that every remote grant is exactly `RWAIT`+1 cycles long and that `rem_wait` appears only inside it.

The directed scenarios cover the behaviour that depends on stimulus sequences:
- the local channel winning when all three masters request at once;
- the CPU keeping the bus while a local request waits;
- a remote byte that runs to its full length after its request is withdrawn;
- the exact cycle position of the wait indication;
- the single idle cycle between back-to-back remote bytes.

// File: rtl/dmabus_pkg.sv
package dmabus_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_LOC  = 2'd1,
    OWN_CPU  = 2'd2,
    OWN_REM  = 2'd3
  } owner_e;

  // Fixed-order choice among active requests (all active high here).
  function automatic owner_e pick_owner(input logic loc, input logic cpu, input logic rem);
    owner_e w;
    w = OWN_NONE;
    if (rem) w = OWN_REM;
    if (cpu) w = OWN_CPU;
    if (loc) w = OWN_LOC;
    return w;
  endfunction

endpackage

// File: rtl/dmabus_pick.sv
module dmabus_pick
  import dmabus_pkg::*;
(
  input  logic   loc_req,
  input  logic   cpu_req_n,
  input  logic   rem_req,
  output owner_e winner
);
  logic cpu_act;

  assign cpu_act = ~cpu_req_n;
  assign winner  = pick_owner(loc_req, cpu_act, rem_req);
endmodule

// File: rtl/dmabus_waitcnt.sv
module dmabus_waitcnt #(
  parameter int RWAIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last,
  output logic waiting
);
  localparam int CNT_W = (RWAIT < 1) ? 1 : $clog2(RWAIT + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(RWAIT);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (!run) cnt <= '0;
    else if (cnt != CNT_END) cnt <= cnt + 1'b1;
  end

  assign last    = run && (cnt == CNT_END);
  assign waiting = run && (cnt != CNT_END);
endmodule

// File: rtl/dmabus_arbiter.sv
module dmabus_arbiter
  import dmabus_pkg::*;
#(
  parameter int RWAIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loc_req,
  output logic loc_ack,
  input  logic cpu_req_n,
  output logic cpu_en,
  input  logic rem_req,
  output logic rem_ack,
  output logic rem_wait
);
  owner_e state, nxt, winner;
  logic   rem_last, rem_waiting, rem_run;

  dmabus_pick u_pick (
    .loc_req   (loc_req),
    .cpu_req_n (cpu_req_n),
    .rem_req   (rem_req),
    .winner    (winner)
  );

  assign rem_run = (state == OWN_REM);

  dmabus_waitcnt #(.RWAIT(RWAIT)) u_wcnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (rem_run),
    .last    (rem_last),
    .waiting (rem_waiting)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      OWN_NONE: nxt = winner;
      OWN_LOC:  nxt = loc_req    ? OWN_LOC : OWN_NONE;
      OWN_CPU:  nxt = !cpu_req_n ? OWN_CPU : OWN_NONE;
      OWN_REM:  nxt = rem_last   ? OWN_NONE : OWN_REM;
      default:  nxt = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= OWN_NONE;
    else        state <= nxt;
  end

  assign loc_ack  = (state == OWN_LOC);
  assign cpu_en   = (state == OWN_CPU);
  assign rem_ack  = rem_run;
  assign rem_wait = rem_waiting;
endmodule

// File: rtl/dmabus_arbiter_chk.sv
module dmabus_arbiter_chk #(
  parameter int RWAIT = 3
) (
  input logic clk,
  input logic rst_n,
  input logic loc_req,
  input logic loc_ack,
  input logic cpu_req_n,
  input logic cpu_en,
  input logic rem_req,
  input logic rem_ack,
  input logic rem_wait
);
  localparam int RC_W = $clog2(RWAIT + 2) + 1;

  logic [RC_W-1:0] rcnt;
  logic            any_g;

  assign any_g = loc_ack | cpu_en | rem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rcnt <= '0;
    else if (rem_ack) rcnt <= rcnt + 1'b1;
    else              rcnt <= '0;
  end

  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({loc_ack, cpu_en, rem_ack}));

  p_loc_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_g && loc_req) |=> loc_ack);

  p_loc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_ack && loc_req) |=> loc_ack);

  p_loc_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_ack && !loc_req) |=> !loc_ack);

  p_cpu_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_g && !cpu_req_n && !loc_req) |=> cpu_en);

  p_cpu_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && !cpu_req_n) |=> cpu_en);

  p_rem_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_g && !(rem_req && !loc_req && cpu_req_n)) |=> !rem_ack);

  p_rem_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rem_ack |-> (rcnt <= RC_W'(RWAIT)));

  p_rem_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_ack && (rcnt < RC_W'(RWAIT))) |=> rem_ack);

  p_wait_in_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rem_wait |-> rem_ack);

  p_wait_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_ack && (rcnt == RC_W'(RWAIT))) |-> !rem_wait);

  p_gap_loc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loc_ack |=> !cpu_en && !rem_ack);

  p_gap_cpu_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en |=> !loc_ack && !rem_ack);

  p_gap_rem_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rem_ack |=> !loc_ack && !cpu_en);
endmodule

bind dmabus_arbiter dmabus_arbiter_chk #(.RWAIT(RWAIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .loc_req   (loc_req),
  .loc_ack   (loc_ack),
  .cpu_req_n (cpu_req_n),
  .cpu_en    (cpu_en),
  .rem_req   (rem_req),
  .rem_ack   (rem_ack),
  .rem_wait  (rem_wait)
);

// File: tb/sim_dmabus_arbiter.sv
`timescale 1ns/1ps
module sim_dmabus_arbiter;
  localparam int RWAIT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loc_req = 1'b0, cpu_req_n = 1'b1, rem_req = 1'b0;
  logic loc_ack, cpu_en, rem_ack, rem_wait;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  dmabus_arbiter #(.RWAIT(RWAIT)) u0 (
    .clk(clk), .rst_n(rst_n),
    .loc_req(loc_req), .loc_ack(loc_ack),
    .cpu_req_n(cpu_req_n), .cpu_en(cpu_en),
    .rem_req(rem_req), .rem_ack(rem_ack), .rem_wait(rem_wait)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {loc_ack,cpu_en,rem_ack,rem_wait} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {loc_ack, cpu_en, rem_ack, rem_wait};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    step();
    chk("R1 during reset", outs(), 4'b0000);
    rst_n = 1'b1;
    step();
    chk("R1 after reset", outs(), 4'b0000);
  endtask

  task automatic t_local_cpu();
    loc_req = 1; cpu_req_n = 0; rem_req = 1;
    step();
    chk("R3 local wins all three", outs(), 4'b1000);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R4 local held", outs(), 4'b1000);
    end
    rem_req = 0; loc_req = 0;
    step();
    chk("R9 gap after local", outs(), 4'b0000);
    step();
    chk("R5 cpu granted", outs(), 4'b0100);
    loc_req = 1;
    step();
    chk("R9 cpu not pre-empted", outs(), 4'b0100);
    step();
    chk("R5 cpu held", outs(), 4'b0100);
    cpu_req_n = 1;
    step();
    chk("R9 gap after cpu", outs(), 4'b0000);
    step();
    chk("R3 local after gap", outs(), 4'b1000);
    loc_req = 0;
    step();
    chk("R4 local dropped", outs(), 4'b0000);
    step();
  endtask

  task automatic t_remote_blocked();
    rem_req = 1; cpu_req_n = 0;
    step();
    chk("R6 cpu beats remote", outs(), 4'b0100);
    cpu_req_n = 1; rem_req = 0;
    step();
    step();
    chk("R6 no remote without request", outs(), 4'b0000);
  endtask

  task automatic t_remote_byte();
    rem_req = 1;
    step();
    rem_req = 0;
    loc_req = 1;
    for (int i = 0; i <= RWAIT; i++) begin
      chk((i < RWAIT) ? "R8 wait cycle" : "R8 data cycle", outs(),
          (i < RWAIT) ? 4'b0011 : 4'b0010);
      if (i == RWAIT) chk("R7 full length despite drop", {3'b0, rem_ack}, 4'b0001);
      step();
    end
    chk("R7 remote ends, R9 gap", outs(), 4'b0000);
    step();
    chk("R9 local after remote", outs(), 4'b1000);
    loc_req = 0;
    step();
    step();
  endtask

  task automatic t_remote_b2b();
    rem_req = 1;
    step();
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i <= RWAIT; i++) begin
        chk("R10 byte grant", {2'b0, rem_ack, rem_wait}, {2'b0, 1'b1, (i < RWAIT)});
        step();
      end
      chk("R10 single idle cycle", outs(), 4'b0000);
      step();
    end
    chk("R10 third byte starts", outs(), 4'b0011);
    rem_req = 0;
    repeat (RWAIT + 2) step();
    chk("R2 all quiet", outs(), 4'b0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_local_cpu();
    t_remote_blocked();
    t_remote_byte();
    t_remote_b2b();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule